// File: doc/BRIEF.md
# Serial RAM power-up init sequencer

This block brings a serial pseudo-static RAM into service after reset. It drives the generic command port of a command engine. Each command is presented as an opcode with a quad/serial form flag, an address length and a receive length. The sequence starts by forcing the device out of quad mode. It then reads the 24-bit device ID and checks it, retrying the read once if the check fails. From the extended ID it decodes the device capacity, and it recognises one legacy part that needs an extra clock after chip select rises.

Once the ID is accepted, the block resets the device with a two-command sequence. It then waits a configurable number of cycles and switches the device into quad mode. At the end it reports done or fail, the detected size, and the clock-tail mode that the cache port should use from then on. While it is probing, it asks the command port to run with the one-extra-clock tail.

Top module: `sram_boot_seq`

## Requirements
- R1: While rst_ni is low: cmd_valid_o, done_o, fail_o and cache_tail_o are 0, clk_tail_o is 1, and size_o is 3 (unknown).
- R2: The first command issued is opcode 0xF5 in quad form (cmd_quad_o=1), with zero address bits and zero receive bits, and clk_tail_o=1.
- R3: The ID read is opcode 0x9F in serial form (cmd_quad_o=0), with cmd_addr_bits_o=24, cmd_rx_bits_o=24 and clk_tail_o=1. The ID is the value on rsp_data_i in the cycle cmd_done_i is high.
- R4: A command holds cmd_valid_o and its fields steady until cmd_done_i is seen. cmd_valid_o then stays low for at least one cycle, exactly one between commands other than around the reset wait. cmd_done_i has no effect while cmd_valid_o is low.
- R5: An ID is accepted only when bits [15:8] equal 0x5D. A rejected first read is repeated once. A second rejection raises fail_o and issues no further command.
- R6: size_o decodes extended ID bits [23:21] (ID bits [23:16] form the extended ID) as 0 for 16 Mbit, 1 for 32 Mbit and 2 for 64 Mbit. An extended ID of exactly 0x26 gives 2. Every other code gives 3.
- R7: An extended ID of exactly 0x20 sets cache_tail_o=1 and keeps clk_tail_o=1 on the reset and quad-enable commands. Any other accepted ID gives cache_tail_o=0 and clk_tail_o=0 on those commands.
- R8: After acceptance the commands 0x66, 0x99 and 0x35 follow in that order, each in serial form with zero address and receive bits.
- R9: cmd_valid_o stays low for exactly RST_WAIT_CYC cycles between the cycle 0x99 is accepted and the issue of 0x35.
- R10: done_o rises after 0x35 is accepted. done_o and fail_o are final states, never both high, and no command is issued in either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_o | output | 1 | Command presented to the engine |
| cmd_op_o | output | 8 | Command opcode |
| cmd_quad_o | output | 1 | 1 = send in quad form, 0 = serial form |
| cmd_addr_bits_o | output | LEN_W | Address phase length in bits |
| cmd_rx_bits_o | output | LEN_W | Receive phase length in bits |
| clk_tail_o | output | 1 | 1 = command port runs with one extra clock after CS rises |
| cmd_done_i | input | 1 | Engine finished the presented command |
| rsp_data_i | input | 24 | Received data, valid with cmd_done_i |
| done_o | output | 1 | Sequence completed |
| fail_o | output | 1 | ID rejected twice |
| size_o | output | 2 | Detected size code |
| cache_tail_o | output | 1 | Clock-tail mode for the cache port |

## Verification
The bench builds the block with RST_WAIT_CYC set to 5 and ID_RETRIES left at 1. The short wait lets the exact idle count before quad enable be measured in each run. The single retry keeps both the recovered-ID path and the double-failure path reachable in a handful of cycles. Engine latency varies per vector between one and three cycles, so both back-to-back and held command phases occur.

// File: rtl/sram_boot_pkg.sv
`timescale 1ns/1ps
package sram_boot_pkg;
  localparam logic [7:0] OP_QUAD_EXIT  = 8'hF5;
  localparam logic [7:0] OP_READ_ID    = 8'h9F;
  localparam logic [7:0] OP_RST_ENABLE = 8'h66;
  localparam logic [7:0] OP_RST_DO     = 8'h99;
  localparam logic [7:0] OP_QUAD_ENTER = 8'h35;
  localparam logic [7:0] OP_NONE       = 8'h00;

  localparam logic [7:0] GOOD_DIE      = 8'h5D;
  localparam logic [7:0] EID_TRIAL64   = 8'h26;
  localparam logic [7:0] EID_LEGACY32  = 8'h20;
  localparam int unsigned ID_W         = 24;

  typedef enum logic [1:0] {
    SZ_16M = 2'd0,
    SZ_32M = 2'd1,
    SZ_64M = 2'd2,
    SZ_UNK = 2'd3
  } size_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_EXIT, ST_GAP, ST_ID, ST_CHECK,
    ST_RSTEN, ST_RST, ST_WAIT, ST_QEN, ST_DONE, ST_FAIL
  } state_e;
endpackage

// File: rtl/sram_id_decode.sv
`timescale 1ns/1ps
module sram_id_decode
  import sram_boot_pkg::*;
(
  input  logic [ID_W-1:0] id_i,
  output logic            ok_o,
  output size_e           size_o,
  output logic            legacy_o
);
  logic [7:0] eid;
  logic [2:0] code;

  assign eid      = id_i[23:16];
  assign code     = eid[7:5];
  assign ok_o     = (id_i[15:8] == GOOD_DIE);
  assign legacy_o = (eid == EID_LEGACY32);

  // trial 64 Mbit part carries a 32 Mbit code, so it takes priority
  always_comb begin
    if (code == 3'd2 || eid == EID_TRIAL64) size_o = SZ_64M;
    else if (code == 3'd1)                 size_o = SZ_32M;
    else if (code == 3'd0)                 size_o = SZ_16M;
    else                                   size_o = SZ_UNK;
  end
endmodule

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_cmd_enc.sv
`timescale 1ns/1ps
module sram_cmd_enc
  import sram_boot_pkg::*;
#(
  parameter int unsigned LEN_W = 6
) (
  input  state_e           state_i,
  output logic             valid_o,
  output logic [7:0]       op_o,
  output logic             quad_o,
  output logic [LEN_W-1:0] addr_bits_o,
  output logic [LEN_W-1:0] rx_bits_o
);
  always_comb begin
    valid_o     = 1'b1;
    quad_o      = 1'b0;
    addr_bits_o = '0;
    rx_bits_o   = '0;
    unique case (state_i)
      ST_EXIT: begin
        op_o   = OP_QUAD_EXIT;
        quad_o = 1'b1;
      end
      ST_ID: begin
        op_o        = OP_READ_ID;
        addr_bits_o = LEN_W'(ID_W);
        rx_bits_o   = LEN_W'(ID_W);
      end
      ST_RSTEN: op_o = OP_RST_ENABLE;
      ST_RST:   op_o = OP_RST_DO;
      ST_QEN:   op_o = OP_QUAD_ENTER;
      default: begin
        op_o    = OP_NONE;
        valid_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sram_boot_seq.sv
`timescale 1ns/1ps
module sram_boot_seq
  import sram_boot_pkg::*;
#(
  parameter int unsigned RST_WAIT_CYC = 200,
  parameter int unsigned ID_RETRIES   = 1,
  parameter int unsigned LEN_W        = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             cmd_valid_o,
  output logic [7:0]       cmd_op_o,
  output logic             cmd_quad_o,
  output logic [LEN_W-1:0] cmd_addr_bits_o,
  output logic [LEN_W-1:0] cmd_rx_bits_o,
  output logic             clk_tail_o,
  input  logic             cmd_done_i,
  input  logic [23:0]      rsp_data_i,
  output logic             done_o,
  output logic             fail_o,
  output logic [1:0]       size_o,
  output logic             cache_tail_o
);
  localparam int unsigned WAIT_W = (RST_WAIT_CYC < 2) ? 1 : $clog2(RST_WAIT_CYC + 1);
  localparam int unsigned TRY_W  = (ID_RETRIES < 1) ? 1 : $clog2(ID_RETRIES + 1);
  localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(RST_WAIT_CYC - 1);

  state_e            state_q, state_d, ret_q, ret_d;
  logic [ID_W-1:0]   id_q;
  logic [TRY_W-1:0]  tries_q;
  logic              probe_q, legacy_q;
  size_e             size_q;
  logic              id_ok, id_legacy, wait_zero, wait_load, accept;
  size_e             id_size;

  sram_cmd_enc #(.LEN_W(LEN_W)) u_enc (
    .state_i     (state_q),
    .valid_o     (cmd_valid_o),
    .op_o        (cmd_op_o),
    .quad_o      (cmd_quad_o),
    .addr_bits_o (cmd_addr_bits_o),
    .rx_bits_o   (cmd_rx_bits_o)
  );

  sram_id_decode u_dec (
    .id_i     (id_q),
    .ok_o     (id_ok),
    .size_o   (id_size),
    .legacy_o (id_legacy)
  );

  assign accept    = cmd_valid_o && cmd_done_i;
  assign wait_load = (state_q == ST_RST) && cmd_done_i;

  sram_wait_timer #(.W(WAIT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wait_load),
    .load_val_i (WAIT_LOAD),
    .zero_o     (wait_zero)
  );

  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    unique case (state_q)
      ST_IDLE:  state_d = ST_EXIT;
      ST_EXIT:  if (accept) begin state_d = ST_GAP; ret_d = ST_ID; end
      ST_GAP:   state_d = ret_q;
      ST_ID:    if (accept) state_d = ST_CHECK;
      ST_CHECK: begin
        if (id_ok)                                state_d = ST_RSTEN;
        else if (tries_q < TRY_W'(ID_RETRIES))   state_d = ST_ID;
        else                                      state_d = ST_FAIL;
      end
      ST_RSTEN: if (accept) begin state_d = ST_GAP; ret_d = ST_RST; end
      ST_RST:   if (accept) state_d = ST_WAIT;
      ST_WAIT:  if (wait_zero) state_d = ST_QEN;
      ST_QEN:   if (accept) state_d = ST_DONE;
      default:  state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ret_q    <= ST_IDLE;
      id_q     <= '0;
      tries_q  <= '0;
      probe_q  <= 1'b1;
      legacy_q <= 1'b0;
      size_q   <= SZ_UNK;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      if (state_q == ST_ID && accept) id_q <= rsp_data_i;
      if (state_q == ST_CHECK) begin
        if (id_ok) begin
          probe_q  <= 1'b0;
          legacy_q <= id_legacy;
          size_q   <= id_size;
        end else begin
          tries_q <= tries_q + 1'b1;
        end
      end
    end
  end

  assign done_o       = (state_q == ST_DONE);
  assign fail_o       = (state_q == ST_FAIL);
  assign size_o       = size_q;
  assign cache_tail_o = legacy_q;
  assign clk_tail_o   = (done_o || fail_o) ? 1'b0 : (probe_q || legacy_q);
endmodule

// File: rtl/sram_boot_seq_chk.sv
`timescale 1ns/1ps
module sram_boot_seq_chk
  import sram_boot_pkg::*;
#(
  parameter int unsigned LEN_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_o,
  input logic [7:0]       cmd_op_o,
  input logic             cmd_quad_o,
  input logic [LEN_W-1:0] cmd_addr_bits_o,
  input logic [LEN_W-1:0] cmd_rx_bits_o,
  input logic             clk_tail_o,
  input logic             cmd_done_i,
  input logic             done_o,
  input logic             fail_o
);
  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_quad_o)); // R4
  AST_GAP_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_done_i |=> !cmd_valid_o); // R4
  AST_EXIT_QUAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_op_o == OP_QUAD_EXIT |-> cmd_quad_o && clk_tail_o && cmd_rx_bits_o == '0); // R2
  AST_ID_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_op_o == OP_READ_ID |-> !cmd_quad_o && clk_tail_o
      && cmd_addr_bits_o == LEN_W'(24) && cmd_rx_bits_o == LEN_W'(24)); // R3
  AST_LATE_SERIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && (cmd_op_o == OP_RST_ENABLE || cmd_op_o == OP_RST_DO || cmd_op_o == OP_QUAD_ENTER)
      |-> !cmd_quad_o && cmd_addr_bits_o == '0); // R8
  AST_DONE_FINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && !cmd_valid_o); // R10
  AST_FAIL_FINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> fail_o && !cmd_valid_o); // R5
  AST_END_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o)); // R10
endmodule

bind sram_boot_seq sram_boot_seq_chk #(.LEN_W(LEN_W)) chk_i (.*);

// File: tb/sram_boot_seq_tb.sv
`timescale 1ns/1ps
module sram_boot_seq_tb_top;
  localparam int unsigned WAIT_CYC = 5;
  localparam int unsigned LEN_W    = 6;

  typedef struct packed {
    logic [3:0]  lat;
    logic [23:0] id1;
    logic [23:0] id2;
    logic        x_fail;
    logic [1:0]  x_size;
    logic        x_leg;
    logic [1:0]  x_reads;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    {4'd1, 24'h405D00, 24'h000000, 1'b0, 2'd2, 1'b0, 2'd1},  // 64 Mbit by code
    {4'd2, 24'h205D12, 24'h000000, 1'b0, 2'd1, 1'b1, 2'd1},  // legacy 32 Mbit
    {4'd3, 24'h265DAA, 24'h000000, 1'b0, 2'd2, 1'b0, 2'd1},  // trial 64 override
    {4'd1, 24'h000000, 24'h1F5D00, 1'b0, 2'd0, 1'b0, 2'd2},  // retry recovers, 16 Mbit
    {4'd2, 24'h5D0000, 24'h00AA00, 1'b1, 2'd3, 1'b0, 2'd2},  // two rejections
    {4'd1, 24'hE05D00, 24'h000000, 1'b0, 2'd3, 1'b0, 2'd1},  // unknown size code
    {4'd3, 24'h215D00, 24'h000000, 1'b0, 2'd1, 1'b0, 2'd1},  // 32 Mbit, not legacy
    {4'd2, 24'h5D5C00, 24'h605D00, 1'b0, 2'd3, 1'b0, 2'd2}   // near-miss die byte
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cmd_valid_o, cmd_quad_o, clk_tail_o, done_o, fail_o, cache_tail_o;
  logic [7:0]       cmd_op_o;
  logic [LEN_W-1:0] cmd_addr_bits_o, cmd_rx_bits_o;
  logic [1:0]       size_o;
  logic             eng_done = 1'b0, poke = 1'b0;
  logic             cmd_done_i;
  logic [23:0]      rsp_data_i = '0;

  assign cmd_done_i = eng_done | poke;

  always #2.5 clk = ~clk;

  sram_boot_seq #(.RST_WAIT_CYC(WAIT_CYC), .ID_RETRIES(1), .LEN_W(LEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_quad_o(cmd_quad_o),
    .cmd_addr_bits_o(cmd_addr_bits_o), .cmd_rx_bits_o(cmd_rx_bits_o),
    .clk_tail_o(clk_tail_o), .cmd_done_i(cmd_done_i), .rsp_data_i(rsp_data_i),
    .done_o(done_o), .fail_o(fail_o), .size_o(size_o), .cache_tail_o(cache_tail_o)
  );

  int checks = 0, failures = 0;
  int lat_cur = 1, eng_cnt = 0, id_reads = 0, n_log = 0, gap = 0, last_gap = 0;
  logic [23:0] id1_cur = '0, id2_cur = '0;
  logic [7:0] log_op [16];
  logic       log_q [16];
  logic       log_t [16];
  int         log_a [16];
  int         log_r [16];
  int         log_g [16];

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // command engine model
  always @(negedge clk) begin
    if (!rst_ni) begin
      eng_cnt = 0;
      gap = 0;
      eng_done <= 1'b0;
    end else begin
      if (!cmd_valid_o) gap++;
      else if (gap != 0) begin last_gap = gap; gap = 0; end
      if (eng_done) begin
        eng_done <= 1'b0;
        eng_cnt = 0;
      end else if (cmd_valid_o) begin
        if (eng_cnt + 1 >= lat_cur) begin
          eng_done <= 1'b1;
          eng_cnt = 0;
          if (cmd_op_o == 8'h9F) begin
            rsp_data_i <= (id_reads == 0) ? id1_cur : id2_cur;
            id_reads++;
          end
          if (n_log < 16) begin
            log_op[n_log] = cmd_op_o;
            log_q[n_log]  = cmd_quad_o;
            log_t[n_log]  = clk_tail_o;
            log_a[n_log]  = int'(cmd_addr_bits_o);
            log_r[n_log]  = int'(cmd_rx_bits_o);
            log_g[n_log]  = last_gap;
          end
          n_log++;
        end else eng_cnt++;
      end
    end
  end

  task automatic run_vec(input vec_t v, input int idx);
    logic [7:0] x_op [16];
    logic       x_q [16];
    logic       x_t [16];
    int         x_a [16];
    int         n_x, held;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    n_log = 0; id_reads = 0; last_gap = 0;
    lat_cur = int'(v.lat); id1_cur = v.id1; id2_cur = v.id2;
    rst_ni = 1'b1;
    for (int i = 0; i < 2000 && !(done_o || fail_o); i++) @(negedge clk);
    // expected command list from the requirements
    n_x = 0;
    x_op[n_x] = 8'hF5; x_q[n_x] = 1'b1; x_t[n_x] = 1'b1; x_a[n_x] = 0; n_x++;
    for (int k = 0; k < int'(v.x_reads); k++) begin
      x_op[n_x] = 8'h9F; x_q[n_x] = 1'b0; x_t[n_x] = 1'b1; x_a[n_x] = 24; n_x++;
    end
    if (!v.x_fail) begin
      x_op[n_x] = 8'h66; x_q[n_x] = 1'b0; x_t[n_x] = v.x_leg; x_a[n_x] = 0; n_x++;
      x_op[n_x] = 8'h99; x_q[n_x] = 1'b0; x_t[n_x] = v.x_leg; x_a[n_x] = 0; n_x++;
      x_op[n_x] = 8'h35; x_q[n_x] = 1'b0; x_t[n_x] = v.x_leg; x_a[n_x] = 0; n_x++;
    end
    chk(fail_o == v.x_fail, v.x_fail ? "R5 fail_o" : "R10 fail_o", int'(fail_o), int'(v.x_fail));
    chk(done_o == !v.x_fail, "R10 done_o", int'(done_o), int'(!v.x_fail));
    chk(n_log == n_x, "R5/R8 command count", n_log, n_x);
    for (int k = 0; k < n_x && k < n_log; k++) begin
      chk(log_op[k] == x_op[k], (k == 0) ? "R2 opcode" : (x_op[k] == 8'h9F) ? "R3 opcode" : "R8 opcode",
          int'(log_op[k]), int'(x_op[k]));
      chk(log_q[k] == x_q[k], (k == 0) ? "R2 quad form" : "R8 serial form", int'(log_q[k]), int'(x_q[k]));
      chk(log_a[k] == x_a[k] && log_r[k] == x_a[k], (x_a[k] != 0) ? "R3 lengths" : "R2/R8 lengths",
          log_a[k], x_a[k]);
      chk(log_t[k] == x_t[k], (k <= int'(v.x_reads)) ? "R3 probe tail" : "R7 command tail",
          int'(log_t[k]), int'(x_t[k]));
      if (k > 0)
        chk(log_g[k] == ((x_op[k] == 8'h35) ? int'(WAIT_CYC) : 1),
            (x_op[k] == 8'h35) ? "R9 reset wait" : "R4 idle gap",
            log_g[k], (x_op[k] == 8'h35) ? int'(WAIT_CYC) : 1);
    end
    if (!v.x_fail) begin
      chk(size_o == v.x_size, "R6 size_o", int'(size_o), int'(v.x_size));
      chk(cache_tail_o == v.x_leg, "R7 cache_tail_o", int'(cache_tail_o), int'(v.x_leg));
    end
    // R4: done pulse with no command pending changes nothing
    held = n_log;
    poke = 1'b1;
    @(negedge clk);
    poke = 1'b0;
    repeat (3) @(negedge clk);
    chk(n_log == held && !cmd_valid_o, "R4 stray done ignored", n_log, held);
    chk(done_o == !v.x_fail && fail_o == v.x_fail, "R10 final state held",
        int'({done_o, fail_o}), int'({!v.x_fail, v.x_fail}));
    if (idx < 0) $display("unreachable");
  endtask

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(!cmd_valid_o && !done_o && !fail_o, "R1 idle outputs",
        int'({cmd_valid_o, done_o, fail_o}), 0);
    chk(size_o == 2'd3, "R1 size unknown", int'(size_o), 3);
    chk(clk_tail_o == 1'b1 && cache_tail_o == 1'b0, "R1 tail modes",
        int'({clk_tail_o, cache_tail_o}), 2);
    for (int v = 0; v < NV; v++) run_vec(VECS[v], v);
    // directed: reset in mid-sequence returns to the reset state
    rst_ni = 1'b1;
    repeat (1) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(!cmd_valid_o && !done_o && size_o == 2'd3, "R1 reset mid-run",
        int'({cmd_valid_o, done_o, size_o}), 3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule